// File: doc/BRIEF.md
# Receive Channel Reconfiguration Reset Sequencer

This block steps a serial receive channel through a dynamic reconfiguration. A request starts the sequence. The block waits until receive calibration is idle, then raises the analog and digital resets of the channel in the same cycle. The analog reset is held for a minimum time. Only after that does a one-cycle start pulse go to an external reconfiguration agent, and the block then waits for that agent's completion strobe.

When the agent reports completion, the analog reset is released. The digital reset stays asserted until the clock-data-recovery lock input has been high for an unbroken minimum interval, counted only after the analog release. Any low sample of the lock input restarts that interval. Both minimum times are given in nanoseconds and turned into clock cycles from a clock-frequency parameter, rounding up. A busy output covers the whole sequence, and a request that arrives while a sequence is running is dropped.

Top module: `rx_reconfig_seq`

## Requirements
- R1: After synchronous reset, rx_analog_rst, rx_digital_rst, reconfig_start and busy are all 0.
- R2: A sequence begins only in a cycle where cal_busy is sampled 0. A request seen while cal_busy is 1 and no sequence is running is remembered, and the sequence begins on the first clock edge where cal_busy is sampled 0.
- R3: rx_analog_rst and rx_digital_rst rise in the same cycle.
- R4: Whenever rx_analog_rst is 1, rx_digital_rst is also 1.
- R5: reconfig_start is a single-cycle pulse. It is asserted in the cycle after rx_analog_rst has been 1 for exactly HOLD_CYC cycles, where HOLD_CYC = ceil(ANALOG_HOLD_NS * CLK_FREQ_HZ / 1e9), with a minimum of 1.
- R6: rx_analog_rst is released one cycle after reconfig_done is sampled 1 after the start pulse. A reconfig_done seen before the start pulse has no effect.
- R7: rx_digital_rst is released after rx_locked has been sampled 1 on LOCK_CYC consecutive clock edges after the analog release, where LOCK_CYC = ceil(LOCK_HOLD_NS * CLK_FREQ_HZ / 1e9). A sample of 0 restarts the count, and lock samples taken before the analog release do not count.
- R8: busy is 1 from the cycle the resets rise through the last cycle rx_digital_rst is 1, and is 0 otherwise.
- R9: A reconfig_req that arrives while a sequence is running is ignored, so no second sequence follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reconfig_req | input | 1 | Request to run a reconfiguration sequence |
| cal_busy | input | 1 | Receive calibration in progress |
| reconfig_start | output | 1 | One-cycle start pulse to the reconfiguration agent |
| reconfig_done | input | 1 | Completion strobe from the reconfiguration agent |
| rx_locked | input | 1 | Recovery circuit locked to incoming data |
| rx_analog_rst | output | 1 | Analog reset to the receive channel |
| rx_digital_rst | output | 1 | Digital (PCS) reset to the receive channel |
| busy | output | 1 | Sequence in progress |

## Verification
The resets rise one edge after a request is sampled while calibration is idle. The start pulse follows exactly HOLD_CYC cycles of analog reset. The analog reset falls on the edge that samples reconfig_done. The digital reset falls on the LOCK_CYC-th consecutive edge that samples lock high after that. The bench drives inputs and samples outputs on falling clock edges. It counts falling edges from each stimulus to the point where the output changes and compares that count with the exact value derived above, so an off-by-one in either counter shows up as a mismatch.

// File: rtl/rxr_pkg.sv
package rxr_pkg;

    typedef enum logic [2:0] {
        RXR_IDLE      = 3'd0,
        RXR_HOLD      = 3'd1,
        RXR_START     = 3'd2,
        RXR_WAIT_DONE = 3'd3,
        RXR_LOCK      = 3'd4
    } rxr_state_e;

    typedef struct packed {
        logic ana_rst;
        logic dig_rst;
        logic start;
        logic busy;
        logic hold_en;
        logic lock_en;
    } rxr_ctrl_t;

    localparam longint unsigned NS_PER_S = 64'd1_000_000_000;

    // Round a nanosecond interval up to whole clock cycles, at least one.
    function automatic int unsigned ns_to_cycles(input int unsigned freq_hz,
                                                 input int unsigned ns);
        longint unsigned prod;
        longint unsigned cyc;
        prod = longint'(freq_hz) * longint'(ns);
        cyc  = (prod + NS_PER_S - 64'd1) / NS_PER_S;
        if (cyc == 64'd0) cyc = 64'd1;
        return int'(cyc);
    endfunction

    function automatic rxr_ctrl_t decode_state(input rxr_state_e st);
        rxr_ctrl_t c;
        c = '0;
        case (st)
            RXR_HOLD: begin
                c.ana_rst = 1'b1; c.dig_rst = 1'b1; c.busy = 1'b1; c.hold_en = 1'b1;
            end
            RXR_START: begin
                c.ana_rst = 1'b1; c.dig_rst = 1'b1; c.busy = 1'b1; c.start = 1'b1;
            end
            RXR_WAIT_DONE: begin
                c.ana_rst = 1'b1; c.dig_rst = 1'b1; c.busy = 1'b1;
            end
            RXR_LOCK: begin
                c.dig_rst = 1'b1; c.busy = 1'b1; c.lock_en = 1'b1;
            end
            default: c = '0;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/rxr_run_timer.sv
// Counts consecutive cycles in which both en and run are high.
// Any cycle with either low clears the count.
module rxr_run_timer #(
    parameter int unsigned LIMIT = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic en,
    input  logic run,
    output logic expired
);
    localparam int unsigned CW = $clog2(LIMIT + 1);
    localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

    logic [CW-1:0] cnt_q;
    logic          active;

    assign active  = en & run;
    assign expired = active & (cnt_q == LAST);

    always_ff @(posedge clk) begin
        if (rst || !active) begin
            cnt_q <= '0;
        end else if (cnt_q != LAST) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/rxr_seq_fsm.sv
module rxr_seq_fsm
    import rxr_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       req,
    input  logic       cal_busy,
    input  logic       hold_expired,
    input  logic       done,
    input  logic       lock_ok,
    output rxr_state_e state
);
    rxr_state_e state_q, state_d;
    logic       pend_q, pend_d;
    logic       want;

    assign want  = req | pend_q;
    assign state = state_q;

    always_comb begin
        state_d = state_q;
        pend_d  = 1'b0;
        case (state_q)
            RXR_IDLE: begin
                if (want && !cal_busy) state_d = RXR_HOLD;
                else                   pend_d  = want;
            end
            RXR_HOLD:      if (hold_expired) state_d = RXR_START;
            RXR_START:     state_d = RXR_WAIT_DONE;
            RXR_WAIT_DONE: if (done)         state_d = RXR_LOCK;
            RXR_LOCK:      if (lock_ok)      state_d = RXR_IDLE;
            default:       state_d = RXR_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= RXR_IDLE;
            pend_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            pend_q  <= pend_d;
        end
    end
endmodule

// File: rtl/rx_reconfig_seq.sv
module rx_reconfig_seq
    import rxr_pkg::*;
#(
    parameter int unsigned CLK_FREQ_HZ    = 250_000_000,
    parameter int unsigned ANALOG_HOLD_NS = 70_000,
    parameter int unsigned LOCK_HOLD_NS   = 4_000
) (
    input  logic clk,
    input  logic rst,
    input  logic reconfig_req,
    input  logic cal_busy,
    output logic reconfig_start,
    input  logic reconfig_done,
    input  logic rx_locked,
    output logic rx_analog_rst,
    output logic rx_digital_rst,
    output logic busy
);
    localparam int unsigned HOLD_CYC = ns_to_cycles(CLK_FREQ_HZ, ANALOG_HOLD_NS);
    localparam int unsigned LOCK_CYC = ns_to_cycles(CLK_FREQ_HZ, LOCK_HOLD_NS);

    rxr_state_e state;
    rxr_ctrl_t  ctrl;
    logic       hold_expired;
    logic       lock_ok;

    assign ctrl = decode_state(state);

    rxr_seq_fsm u_fsm (
        .clk          (clk),
        .rst          (rst),
        .req          (reconfig_req),
        .cal_busy     (cal_busy),
        .hold_expired (hold_expired),
        .done         (reconfig_done),
        .lock_ok      (lock_ok),
        .state        (state)
    );

    rxr_run_timer #(.LIMIT(HOLD_CYC)) u_hold (
        .clk     (clk),
        .rst     (rst),
        .en      (ctrl.hold_en),
        .run     (1'b1),
        .expired (hold_expired)
    );

    rxr_run_timer #(.LIMIT(LOCK_CYC)) u_lock (
        .clk     (clk),
        .rst     (rst),
        .en      (ctrl.lock_en),
        .run     (rx_locked),
        .expired (lock_ok)
    );

    assign rx_analog_rst  = ctrl.ana_rst;
    assign rx_digital_rst = ctrl.dig_rst;
    assign reconfig_start = ctrl.start;
    assign busy           = ctrl.busy;
endmodule

// File: rtl/rxr_checker.sv
module rxr_checker
    import rxr_pkg::*;
#(
    parameter int unsigned CLK_FREQ_HZ    = 250_000_000,
    parameter int unsigned ANALOG_HOLD_NS = 70_000,
    parameter int unsigned LOCK_HOLD_NS   = 4_000
) (
    input logic clk,
    input logic rst,
    input logic cal_busy,
    input logic reconfig_done,
    input logic rx_locked,
    input logic reconfig_start,
    input logic rx_analog_rst,
    input logic rx_digital_rst,
    input logic busy
);
    localparam int unsigned HOLD_CYC = ns_to_cycles(CLK_FREQ_HZ, ANALOG_HOLD_NS);
    localparam int unsigned LOCK_CYC = ns_to_cycles(CLK_FREQ_HZ, LOCK_HOLD_NS);

    int unsigned ana_run_q;
    int unsigned lock_run_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ana_run_q  <= 0;
            lock_run_q <= 0;
        end else begin
            ana_run_q  <= rx_analog_rst ? ((ana_run_q == 32'hFFFF_FFFF) ? ana_run_q : ana_run_q + 1) : 0;
            lock_run_q <= (rx_locked && !rx_analog_rst) ?
                          ((lock_run_q == 32'hFFFF_FFFF) ? lock_run_q : lock_run_q + 1) : 0;
        end
    end

    assert_cal_idle_R2: assert property (@(posedge clk) disable iff (rst)
        $rose(rx_analog_rst) |-> !$past(cal_busy));

    assert_rise_together_R3: assert property (@(posedge clk) disable iff (rst)
        $rose(rx_analog_rst) |-> $rose(rx_digital_rst));

    assert_ana_needs_dig_R4: assert property (@(posedge clk) disable iff (rst)
        rx_analog_rst |-> rx_digital_rst);

    assert_start_single_R5: assert property (@(posedge clk) disable iff (rst)
        reconfig_start |=> !reconfig_start);

    assert_start_after_hold_R5: assert property (@(posedge clk) disable iff (rst)
        reconfig_start |-> (rx_analog_rst && ana_run_q >= HOLD_CYC));

    assert_release_on_done_R6: assert property (@(posedge clk) disable iff (rst)
        $fell(rx_analog_rst) |-> $past(reconfig_done));

    assert_lock_qualified_R7: assert property (@(posedge clk) disable iff (rst)
        $fell(rx_digital_rst) |-> (lock_run_q >= LOCK_CYC));

    assert_busy_cover_R8: assert property (@(posedge clk) disable iff (rst)
        (rx_analog_rst || rx_digital_rst || reconfig_start) |-> busy);
endmodule

bind rx_reconfig_seq rxr_checker #(
    .CLK_FREQ_HZ    (CLK_FREQ_HZ),
    .ANALOG_HOLD_NS (ANALOG_HOLD_NS),
    .LOCK_HOLD_NS   (LOCK_HOLD_NS)
) u_rxr_checker (
    .clk            (clk),
    .rst            (rst),
    .cal_busy       (cal_busy),
    .reconfig_done  (reconfig_done),
    .rx_locked      (rx_locked),
    .reconfig_start (reconfig_start),
    .rx_analog_rst  (rx_analog_rst),
    .rx_digital_rst (rx_digital_rst),
    .busy           (busy)
);

// File: tb/tb_rx_reconfig_seq.sv
module tb_rx_reconfig_seq;
    localparam int unsigned FREQ    = 250_000_000;
    localparam int unsigned HOLD_NS = 400;  // 100 cycles at 250 MHz
    localparam int unsigned LOCK_NS = 200;  // 50 cycles at 250 MHz
    localparam int HOLD_CYC = 100;
    localparam int LOCK_CYC = 50;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic reconfig_req = 1'b0;
    logic cal_busy = 1'b0;
    logic reconfig_done = 1'b0;
    logic rx_locked = 1'b0;
    logic reconfig_start, rx_analog_rst, rx_digital_rst, busy;

    int n_checks = 0;
    int n_fail   = 0;
    int cyc      = 0;

    always #2 clk = ~clk;

    rx_reconfig_seq #(
        .CLK_FREQ_HZ(FREQ), .ANALOG_HOLD_NS(HOLD_NS), .LOCK_HOLD_NS(LOCK_NS)
    ) dut (
        .clk(clk), .rst(rst), .reconfig_req(reconfig_req), .cal_busy(cal_busy),
        .reconfig_start(reconfig_start), .reconfig_done(reconfig_done),
        .rx_locked(rx_locked), .rx_analog_rst(rx_analog_rst),
        .rx_digital_rst(rx_digital_rst), .busy(busy)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic tick(); @(negedge clk); endtask

    task automatic pulse_req();
        reconfig_req = 1'b1; tick(); reconfig_req = 1'b0;
    endtask

    // After resets rose: count negedges with start low until start is seen.
    task automatic measure_start(input string req, output int n);
        n = 0;
        while (!reconfig_start && n < 10000) begin n++; tick(); end
    endtask

    task automatic give_done();
        reconfig_done = 1'b1; tick(); reconfig_done = 1'b0;
    endtask

    task automatic wait_dig_low(output int n);
        n = 0;
        while (rx_digital_rst && n < 10000) begin tick(); n++; end
    endtask

    task automatic t_reset();
        chk("R1", "ana after reset", rx_analog_rst, 0);
        chk("R1", "dig after reset", rx_digital_rst, 0);
        chk("R1", "start after reset", reconfig_start, 0);
        chk("R1", "busy after reset", busy, 0);
    endtask

    task automatic t_normal();
        int n;
        pulse_req();
        chk("R3", "ana rises", rx_analog_rst, 1);
        chk("R3", "dig rises", rx_digital_rst, 1);
        chk("R8", "busy rises", busy, 1);
        measure_start("R5", n);
        chk("R5", "hold cycles before start", n, HOLD_CYC);
        tick();
        chk("R5", "start one cycle", reconfig_start, 0);
        repeat (5) tick();
        chk("R6", "ana held while waiting done", rx_analog_rst, 1);
        chk("R4", "dig with ana", rx_digital_rst, 1);
        give_done();
        chk("R6", "ana released after done", rx_analog_rst, 0);
        chk("R7", "dig held after ana release", rx_digital_rst, 1);
        rx_locked = 1'b1;
        wait_dig_low(n);
        chk("R7", "lock cycles to dig release", n, LOCK_CYC);
        chk("R8", "busy low at end", busy, 0);
        rx_locked = 1'b0;
        tick();
    endtask

    task automatic t_glitch();
        int n;
        pulse_req();
        measure_start("R5", n);
        tick(); give_done();
        rx_locked = 1'b1;
        repeat (30) tick();
        rx_locked = 1'b0; tick();
        chk("R7", "dig held through glitch", rx_digital_rst, 1);
        rx_locked = 1'b1;
        wait_dig_low(n);
        chk("R7", "count restarts after glitch", n, LOCK_CYC);
        rx_locked = 1'b0; tick();
    endtask

    task automatic t_cal_busy();
        int n;
        cal_busy = 1'b1;
        pulse_req();
        repeat (10) tick();
        chk("R2", "no assert while cal busy", rx_analog_rst, 0);
        chk("R2", "idle while cal busy", busy, 0);
        cal_busy = 1'b0; tick();
        chk("R2", "pending launches when cal idle", rx_analog_rst, 1);
        measure_start("R5", n);
        tick(); give_done();
        rx_locked = 1'b1;
        wait_dig_low(n);
        rx_locked = 1'b0; tick();
    endtask

    task automatic t_ignore_req();
        int n;
        int rises;
        pulse_req();
        repeat (20) tick();
        pulse_req();  // during hold
        measure_start("R5", n);
        tick(); give_done();
        pulse_req();  // during lock wait
        rx_locked = 1'b1;
        wait_dig_low(n);
        rx_locked = 1'b0;
        rises = 0;
        for (int i = 0; i < 30; i++) begin tick(); if (rx_analog_rst || busy) rises++; end
        chk("R9", "no second sequence", rises, 0);
    endtask

    task automatic t_early_done_and_lock();
        int n;
        rx_locked = 1'b1;
        pulse_req();
        repeat (10) tick();
        give_done();  // before start: must be ignored
        chk("R6", "early done ignored", rx_analog_rst, 1);
        n = 11;
        while (!reconfig_start && n < 10000) begin n++; tick(); end
        chk("R5", "start timing with early done", n, HOLD_CYC);
        tick();
        chk("R6", "still waiting for done", rx_analog_rst, 1);
        reconfig_done = 1'b1;
        wait_dig_low(n);
        reconfig_done = 1'b0;
        chk("R7", "lock before release not counted", n, LOCK_CYC + 1);
        rx_locked = 1'b0; tick();
    endtask

    initial begin
        repeat (3) tick();
        rst = 1'b0;
        tick();
        t_reset();
        t_normal();
        t_glitch();
        t_cal_busy();
        t_ignore_req();
        t_early_done_and_lock();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc == 100_000) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected below %0d cycles", cyc, 100_000);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
            $finish;
        end
    end
endmodule